// File: doc/BRIEF.md
# Overcurrent Shutdown and Fault Latch Controller

This block decides when a three-phase gate driver must hold all six of its switches off, and when it reports a fault. It takes four inputs: an overcurrent comparator bit that is already synchronised to the clock, a low-side supply undervoltage flag, an enable level, and a one-cycle pulse that marks each gate switching edge. It produces two outputs. The first is a single kill level that the per-channel output logic uses to force every gate off. The second is an active-low fault indicator.

An overcurrent that arrives outside the blanking window after a switching edge sets a set-dominant latch. The latch holds the kill and the fault for as long as the overcurrent persists. Once the overcurrent has been quiet for a programmed number of clock cycles, the latch releases by itself. That count replaces an external RC timer. The latched state reaches the kill output through a shorter pipeline than it reaches the fault output, so the shutdown always acts before the fault is reported. Undervoltage acts at once and is not latched. Enable acts only on the kill output.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: Take an overcurrent level sampled high at clock edge k, outside blanking. `kill_o` reads 1 from edge k+SHUT_LAT onward, and `fault_n_o` reads 0 from edge k+FLAG_LAT onward. Before those edges, and with no other cause active, they read 0 and 1.
- R2: The latch is set-dominant. However long the overcurrent stays high, `kill_o` stays 1 and `fault_n_o` stays 0, even past the clear interval.
- R3: Let m be the last edge with a qualified overcurrent. `kill_o` returns to 0 at edge m+CLR_CYC+SHUT_LAT and `fault_n_o` returns to 1 at edge m+CLR_CYC+FLAG_LAT, unless undervoltage or enable holds them.
- R4: The clear countdown is held at zero while the overcurrent is high. It begins only on the first quiet edge, so release is timed from the last overcurrent edge and not from the first.
- R5: While undervoltage is sampled high, `kill_o` reads 1 and `fault_n_o` reads 0 one edge later. Both return to 0 and 1 one edge after undervoltage is sampled low, with no hold-off.
- R6: While `enable_i` is sampled low, `kill_o` reads 1 one edge later. `enable_i` never changes `fault_n_o`, and it neither sets nor clears the latch.
- R7: `gate_edge_i` sampled high at edge e masks the overcurrent on edges e through e+BLANK_CYC-1. An overcurrent confined to those edges has no effect. One that is still high at edge e+BLANK_CYC trips at that edge.
- R8: SHUT_LAT is less than FLAG_LAT. On a trip, `kill_o` rises before `fault_n_o` falls. On release, `kill_o` falls before `fault_n_o` rises.
- R9: While `rst_n` is low, `kill_o` is 1 and `fault_n_o` is 1: outputs off, no fault.
- R10: A new overcurrent during the countdown sets the latch again. Release is then timed from the end of the new overcurrent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| oc_i | input | 1 | Synchronised overcurrent comparator level, 1 = overcurrent |
| uv_i | input | 1 | Low-side supply undervoltage level, 1 = undervoltage |
| enable_i | input | 1 | Output enable level, 0 forces outputs off |
| gate_edge_i | input | 1 | One-cycle pulse on each gate switching edge, starts blanking |
| kill_o | output | 1 | 1 = force all six gate outputs off |
| fault_n_o | output | 1 | Active-low fault indicator |

## Verification
The assertions take for granted that every input is synchronous to `clk` and changes only between edges. They also assume that the parameters satisfy FLAG_LAT > SHUT_LAT >= 1, CLR_CYC >= 2 and CLR_CYC > FLAG_LAT - SHUT_LAT, so the latch stays set long enough for the fault pipeline to catch up with the kill pipeline. The stimulus changes inputs only on falling edges, keeps each switching-edge pulse one cycle wide, and spaces the scenarios so that each trip has fully released before the next one starts. This spacing lets every expected edge be computed from a single event.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  // Latch phases: clear, held by an active overcurrent, counting the quiet interval.
  typedef enum logic [1:0] {
    LAT_CLEAR = 2'd0,
    LAT_HELD  = 2'd1,
    LAT_QUIET = 2'd2
  } lat_state_e;
endpackage

// File: rtl/ocp_blanker.sv
module ocp_blanker #(
  parameter int BLANK_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_edge_i,
  input  logic oc_i,
  output logic oc_qual_o
);
  localparam int BW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);

  logic [BW-1:0] blank_cnt, blank_cnt_n;
  logic          blanking;

  always_comb begin
    blank_cnt_n = blank_cnt;
    if (gate_edge_i) begin
      blank_cnt_n = BW'(BLANK_CYC - 1);
    end else if (blank_cnt != '0) begin
      blank_cnt_n = blank_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_cnt <= '0;
    end else begin
      blank_cnt <= blank_cnt_n;
    end
  end

  assign blanking  = gate_edge_i | (blank_cnt != '0);
  assign oc_qual_o = oc_i & ~blanking;

  AST_BLANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    blank_cnt <= BW'(BLANK_CYC - 1)); // R7
  AST_BLANK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_edge_i && BLANK_CYC > 1) |=> !oc_qual_o); // R7
endmodule

// File: rtl/ocp_delay.sv
module ocp_delay #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [DEPTH-1:0] sr, sr_n;

      always_comb begin
        sr_n[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
          sr_n[i] = sr[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr <= '0;
        end else begin
          sr <= sr_n;
        end
      end

      assign dout = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch
  import ocp_pkg::*;
#(
  parameter int CLR_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_q,
  output logic tripped_o
);
  localparam int CW = (CLR_CYC < 2) ? 1 : $clog2(CLR_CYC);
  localparam logic [CW-1:0] LAST = CW'(CLR_CYC - 1);

  lat_state_e    state, state_n;
  logic [CW-1:0] clr_cnt, clr_cnt_n;

  always_comb begin
    state_n   = state;
    clr_cnt_n = clr_cnt;
    if (oc_q) begin
      // set wins over any clearing in progress
      state_n   = LAT_HELD;
      clr_cnt_n = '0;
    end else begin
      unique case (state)
        LAT_HELD: begin
          state_n   = LAT_QUIET;
          clr_cnt_n = CW'(1);
        end
        LAT_QUIET: begin
          if (clr_cnt == LAST) begin
            state_n   = LAT_CLEAR;
            clr_cnt_n = '0;
          end else begin
            clr_cnt_n = clr_cnt + 1'b1;
          end
        end
        default: begin
          state_n   = LAT_CLEAR;
          clr_cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= LAT_CLEAR;
      clr_cnt <= '0;
    end else begin
      state   <= state_n;
      clr_cnt <= clr_cnt_n;
    end
  end

  assign tripped_o = (state != LAT_CLEAR);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    oc_q |=> tripped_o); // R2
  AST_TIMER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    oc_q |=> (clr_cnt == '0)); // R4
  AST_CLEAN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tripped_o) |-> ($past(!oc_q) && $past(clr_cnt == LAST))); // R3
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LAT_QUIET && oc_q) |=> (state == LAT_HELD)); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt <= LAST); // R3
endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl #(
  parameter int BLANK_CYC = 6,
  parameter int SHUT_LAT  = 2,
  parameter int FLAG_LAT  = 5,
  parameter int CLR_CYC   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_i,
  input  logic uv_i,
  input  logic enable_i,
  input  logic gate_edge_i,
  output logic kill_o,
  output logic fault_n_o
);
  // One cycle of each latency sits in the output register.
  localparam int SHUT_DEPTH = SHUT_LAT - 1;
  localparam int FLAG_DEPTH = FLAG_LAT - 1;

  logic oc_qual;
  logic tripped;
  logic shut_d, flag_d;
  logic kill_q, kill_n;
  logic fault_q, fault_n;

  ocp_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_edge_i(gate_edge_i),
    .oc_i       (oc_i),
    .oc_qual_o  (oc_qual)
  );

  ocp_fault_latch #(.CLR_CYC(CLR_CYC)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .oc_q     (oc_qual),
    .tripped_o(tripped)
  );

  ocp_delay #(.DEPTH(SHUT_DEPTH)) u_shut_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (tripped),
    .dout (shut_d)
  );

  ocp_delay #(.DEPTH(FLAG_DEPTH)) u_flag_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (tripped),
    .dout (flag_d)
  );

  always_comb begin
    kill_n  = shut_d | uv_i | ~enable_i;
    fault_n = flag_d | uv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kill_q  <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      kill_q  <= kill_n;
      fault_q <= fault_n;
    end
  end

  assign kill_o    = kill_q;
  assign fault_n_o = ~fault_q;

  AST_TRIP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    shut_d |=> kill_o); // R1
  AST_UV_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (kill_o && !fault_n_o)); // R5
  AST_EN_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> kill_o); // R6
  AST_NO_TRIP_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> !$past(gate_edge_i)); // R7
  AST_SHUT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_d) |-> shut_d); // R8
  AST_SHUT_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shut_d) |-> flag_d); // R8
endmodule

// File: tb/tb_ocp_fault_ctrl.sv
module tb_ocp_fault_ctrl;
  localparam int B = 6;
  localparam int S = 2;
  localparam int F = 5;
  localparam int C = 20;

  typedef struct {
    int    cyc;
    logic  kill;
    logic  fault_n;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, oc, uv, en, gedge;
  logic kill, fault_n;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];

  always #4 clk = ~clk; // 125 MHz

  ocp_fault_ctrl #(.BLANK_CYC(B), .SHUT_LAT(S), .FLAG_LAT(F), .CLR_CYC(C)) dut (
    .clk(clk), .rst_n(rst_n), .oc_i(oc), .uv_i(uv), .enable_i(en),
    .gate_edge_i(gedge), .kill_o(kill), .fault_n_o(fault_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(logic k, logic f, string tag);
    checks++;
    if (kill !== k || fault_n !== f) begin
      errors++;
      $display("FAIL %s cyc %0d: kill/fault_n = %b%b expected %b%b", tag, cyc, kill, fault_n, k, f);
    end
  endtask

  task automatic expect_at(int c, logic k, logic f, string tag);
    exp_t e;
    e.cyc = c; e.kill = k; e.fault_n = f; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic go_to(int c);
    @(negedge clk);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops scoreboard items that fall due on this cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].cyc == cyc) begin
          compare(sb[i].kill, sb[i].fault_n, sb[i].tag);
          sb.delete(i);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t, k, m, m2, e, u, v;
    rst_n = 1'b0; oc = 1'b0; uv = 1'b0; en = 1'b1; gedge = 1'b0;
    repeat (3) @(negedge clk);
    compare(1'b1, 1'b1, "R9 reset state");
    rst_n = 1'b1;
    t = cyc;
    expect_at(t + 3, 1'b0, 1'b1, "R9 idle after reset");
    go_to(t + 5);

    // trip, long hold, release (R1 R2 R4 R3 R8)
    t = cyc; oc = 1'b1; k = t + 1;
    m = k + C + 9;
    expect_at(k + S - 1, 1'b0, 1'b1, "R1 before kill");
    expect_at(k + S,     1'b1, 1'b1, "R1 kill latency");
    expect_at(k + F - 1, 1'b1, 1'b1, "R8 kill before flag");
    expect_at(k + F,     1'b1, 1'b0, "R1 flag latency");
    expect_at(k + C + S + 2, 1'b1, 1'b0, "R2 held past clear interval");
    expect_at(m + S,     1'b1, 1'b0, "R2 still held at drop");
    expect_at(m + C + S - 1, 1'b1, 1'b0, "R4 countdown from last edge");
    expect_at(m + C + S, 1'b0, 1'b0, "R3 kill release");
    expect_at(m + C + F - 1, 1'b0, 1'b0, "R8 kill released first");
    expect_at(m + C + F, 1'b0, 1'b1, "R3 flag release");
    go_to(m);
    oc = 1'b0;
    go_to(m + C + F + 3);

    // re-trip during countdown (R10)
    t = cyc; oc = 1'b1;
    m = t + 2; m2 = m + 10;
    expect_at(m + C + S, 1'b1, 1'b0, "R10 old release suppressed");
    expect_at(m2 + C + S - 1, 1'b1, 1'b0, "R10 hold before new release");
    expect_at(m2 + C + S, 1'b0, 1'b0, "R10 kill release restarted");
    expect_at(m2 + C + F, 1'b0, 1'b1, "R10 flag release restarted");
    go_to(t + 2); oc = 1'b0;
    go_to(m + 9); oc = 1'b1;
    go_to(m + 10); oc = 1'b0;
    go_to(m2 + C + F + 3);

    // overcurrent inside blanking is ignored (R7)
    t = cyc; gedge = 1'b1; oc = 1'b1; e = t + 1;
    expect_at(e + S, 1'b0, 1'b1, "R7 blanked no kill");
    expect_at(e + B + F, 1'b0, 1'b1, "R7 blanked no fault");
    go_to(t + 1); gedge = 1'b0;
    go_to(t + B); oc = 1'b0;
    go_to(e + B + F + 2);

    // overcurrent outlasting blanking trips at the first unmasked edge (R7)
    t = cyc; gedge = 1'b1; oc = 1'b1; e = t + 1; k = e + B;
    expect_at(k + S - 1, 1'b0, 1'b1, "R7 masked until window end");
    expect_at(k + S, 1'b1, 1'b1, "R7 trip after window");
    expect_at(k + F, 1'b1, 1'b0, "R7 fault after window");
    expect_at(k + C + F, 1'b0, 1'b1, "R3 release after blanked trip");
    go_to(t + 1); gedge = 1'b0;
    go_to(t + B + 1); oc = 1'b0;
    go_to(k + C + F + 3);

    // undervoltage, not latched (R5)
    t = cyc; uv = 1'b1; u = t + 1;
    expect_at(u, 1'b1, 1'b0, "R5 uv asserts");
    expect_at(u + 4, 1'b1, 1'b0, "R5 uv held");
    expect_at(u + 5, 1'b0, 1'b1, "R5 uv releases at once");
    go_to(t + 5); uv = 1'b0;
    go_to(u + 8);

    // enable low only kills (R6)
    t = cyc; en = 1'b0; v = t + 1;
    expect_at(v, 1'b1, 1'b1, "R6 enable low kills, no fault");
    expect_at(v + 3, 1'b1, 1'b1, "R6 enable low held");
    expect_at(v + 4, 1'b0, 1'b1, "R6 enable restored");
    go_to(t + 4); en = 1'b1;
    go_to(v + 7);

    // enable low during a trip neither clears nor hides the fault (R6)
    t = cyc; oc = 1'b1; k = t + 1; m = k;
    expect_at(k + F, 1'b1, 1'b0, "R6 fault shown with enable low");
    expect_at(m + C + S, 1'b0, 1'b0, "R6 latch not cleared by enable");
    expect_at(m + C + F, 1'b0, 1'b1, "R6 release on schedule");
    go_to(t + 1); oc = 1'b0; en = 1'b0;
    go_to(k + 5); en = 1'b1;
    go_to(m + C + F + 3);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule